// File: doc/BRIEF.md
# Scan Chain Flush Integrity Tester

This block checks that the scan shift paths of a design work before any captured test vectors go through them. On a start request it takes the shared test-control line into scan mode and holds it there for the whole test. It shifts a repeating serial pattern into every chain at once. It then compares the bits that emerge at each chain's serial output against the pattern it drove earlier, delayed by that chain's length. The pattern makes every cell in every chain see a steady low, a rising edge, a steady high and a falling edge.

The chains may have different lengths. They all share the one control line, so the run length is set by the longest chain. Each shorter chain is compared only during its own four-cycle window, which starts once its contents are fully replaced by known bits. Bits it emits outside that window are ignored.

At the end the block raises done. It raises pass only if every compared bit matched. If a bit did not match, the block keeps the test-cycle index of the first mismatch for diagnosis.

Top module: `scan_flush_tester`

## Requirements
- R1: After reset, and whenever no test runs, scan_tc is 1, every scan_in bit is 0, and done, pass, err and fail_cycle are all 0 until the first test ends.
- R2: A start pulse while idle begins a test. scan_tc is then 0 for exactly longest-chain-length + 4 consecutive cycles. A start pulse during a test has no effect on that length or on the result.
- R3: In test cycle k (k = 0 is the first cycle with scan_tc = 0), every scan_in bit equals bit 1 of k. This gives the serial pattern 0,0,1,1 repeated.
- R4: Chain i, of length L_i, is compared only in test cycles L_i to L_i+3, against the pattern bit driven in cycle k - L_i. Its output in any other cycle, including leftover unknown contents, does not affect the result.
- R5: done goes to 1 in the cycle after the last test cycle and stays at 1 until the next start. pass is 1 exactly when done is 1 and no compared bit mismatched.
- R6: On the first mismatch in a test, err goes to 1 and fail_cycle captures that test-cycle index. Both hold until the next start, and later mismatches do not change them.
- R7: A new start clears done, pass, err and fail_cycle, so each test's result depends only on its own run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the scan chains |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test (ignored while one runs) |
| scan_tc | output | 1 | Shared test control, 0 selects scan shift |
| scan_in | output | NCH | Serial data into each chain |
| scan_out | input | NCH | Serial data out of each chain |
| done | output | 1 | Test finished |
| pass | output | 1 | Test finished with no mismatch |
| err | output | 1 | A mismatch was seen |
| fail_cycle | output | CW | Test-cycle index of the first mismatch |

## Verification
A wrong cycle counter would show up at the ports within a cycle or two. scan_in would leave the 0,0,1,1 rhythm, or scan_tc would stay low for the wrong number of cycles, so that done rises early or late. A wrongly placed compare window behaves differently. It only shows once a chain emits a bad or leftover bit near the window edge, as a false err or a missed one, and as a fail_cycle that is off by the shift. The bench therefore corrupts single chains at the first and last compared cycle and just outside the window. It checks every output on every clock against its own model of the chains.

// File: rtl/scan_flush_tester.sv
module scan_flush_tester #(
  parameter int NCH = 3,
  parameter int LW = 8,
  parameter logic [NCH*LW-1:0] LENS = {8'd3, 8'd12, 8'd5},
  localparam int MAXL = longest(),
  localparam int TOTAL = MAXL + 4,
  localparam int CW = $clog2(TOTAL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           scan_tc,
  output logic [NCH-1:0] scan_in,
  input  logic [NCH-1:0] scan_out,
  output logic           done,
  output logic           pass,
  output logic           err,
  output logic [CW-1:0]  fail_cycle
);

  function automatic int longest();
    int m = 0;
    for (int i = 0; i < NCH; i++)
      if (int'(LENS[i*LW +: LW]) > m) m = int'(LENS[i*LW +: LW]);
    return m;
  endfunction

  localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

  logic          run;
  logic [CW-1:0] cnt;
  logic [NCH-1:0] mis;

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    localparam logic [CW-1:0] LO = CW'(int'(LENS[g*LW +: LW]));
    localparam logic [CW-1:0] HI = CW'(int'(LENS[g*LW +: LW]) + 3);
    logic [CW-1:0] rel;
    logic          in_win;
    assign rel    = cnt - LO;
    assign in_win = run && (cnt >= LO) && (cnt <= HI);
    assign mis[g] = in_win && (scan_out[g] != rel[1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
      done <= 1'b0;
      err <= 1'b0;
      fail_cycle <= '0;
    end else if (run) begin
      if (|mis && !err) begin
        err <= 1'b1;
        fail_cycle <= cnt;
      end
      if (cnt == LAST) begin
        run <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (start) begin
      run <= 1'b1;
      cnt <= '0;
      done <= 1'b0;
      err <= 1'b0;
      fail_cycle <= '0;
    end
  end

  assign scan_tc = ~run;
  assign scan_in = {NCH{run & cnt[1]}};
  assign pass    = done & ~err;

  // R2
  tc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_tc) |-> done);

  // R3
  pattern_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_tc && $past(!scan_tc, 4)) |-> scan_in == $past(scan_in, 4));

  // R3
  pattern_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_tc) |-> scan_in == '0);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R6
  first_fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && $past(err)) |-> $stable(fail_cycle));

  // R6
  err_in_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(!scan_tc));

endmodule

// File: tb/scan_flush_tester_tb.sv
module scan_flush_tester_tb_top;
  localparam int NCH = 3;
  localparam int LEN [NCH] = '{5, 12, 3};
  localparam int TOTAL = 16;
  localparam int CW = 5;

  logic clk = 0, rst_n = 0, start = 0;
  logic scan_tc, done, pass, err;
  logic [NCH-1:0] scan_in, scan_out;
  logic [CW-1:0] fail_cycle;

  always #4 clk = ~clk;

  scan_flush_tester dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_tc(scan_tc),
    .scan_in(scan_in), .scan_out(scan_out), .done(done), .pass(pass),
    .err(err), .fail_cycle(fail_cycle));

  logic [15:0] ch [NCH];
  int fmode [NCH];
  int fat [NCH];

  int r_run = 0, r_cnt = 0, r_done = 0, r_err = 0, r_fc = 0;
  int checks = 0, fails = 0, tc_low = 0;
  bit finished = 0;

  initial for (int i = 0; i < NCH; i++) begin
    ch[i] = 16'hFFFF; fmode[i] = 0; fat[i] = 0;
  end

  always_comb
    for (int i = 0; i < NCH; i++) begin
      logic b;
      b = ch[i][LEN[i]-1];
      case (fmode[i])
        1: scan_out[i] = 1'b1;
        2: scan_out[i] = ~b;
        3: scan_out[i] = (r_run != 0 && r_cnt >= fat[i]) ? ~b : b;
        default: scan_out[i] = b;
      endcase
    end

  always @(posedge clk)
    for (int i = 0; i < NCH; i++)
      if (!scan_tc) ch[i] <= {ch[i][14:0], scan_in[i]};

  always @(posedge clk) begin
    int nrun, ncnt, ndone, nerr, nfc;
    nrun = r_run; ncnt = r_cnt; ndone = r_done; nerr = r_err; nfc = r_fc;
    if (!rst_n) begin
      nrun = 0; ncnt = 0; ndone = 0; nerr = 0; nfc = 0;
    end else if (r_run != 0) begin
      for (int i = 0; i < NCH; i++)
        if (r_cnt >= LEN[i] && r_cnt <= LEN[i] + 3 &&
            scan_out[i] != (((r_cnt - LEN[i]) >> 1) & 1) && nerr == 0) begin
          nerr = 1; nfc = r_cnt;
        end
      if (r_cnt == TOTAL - 1) begin nrun = 0; ndone = 1; end
      else ncnt = r_cnt + 1;
    end else if (start) begin
      nrun = 1; ncnt = 0; ndone = 0; nerr = 0; nfc = 0;
    end
    r_run <= nrun; r_cnt <= ncnt; r_done <= ndone; r_err <= nerr; r_fc <= nfc;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    int pat;
    pat = (r_run != 0) ? ((r_cnt >> 1) & 1) : 0;
    chk(r_run != 0 ? "R2" : "R1", "scan_tc", int'(scan_tc), r_run != 0 ? 0 : 1);
    chk(r_run != 0 ? "R3" : "R1", "scan_in", int'(scan_in), r_run != 0 ? pat * 7 : 0);
    chk("R5", "done", int'(done), r_done);
    chk("R5", "pass", int'(pass), (r_done != 0 && r_err == 0) ? 1 : 0);
    chk("R6", "err", int'(err), r_err);
    chk("R6", "fail_cycle", int'(fail_cycle), r_fc);
    if (!scan_tc) tc_low++;
  end

  task automatic run_one(input string req, input int exp_pass, input int exp_fc, input bit poke);
    @(negedge clk); start = 1; tc_low = 0;
    @(negedge clk); start = 0;
    repeat (6) @(negedge clk);
    if (poke) begin start = 1; @(negedge clk); start = 0; end
    repeat (TOTAL) @(negedge clk);
    chk("R2", "scan cycles", tc_low, TOTAL);
    chk(req, "final pass", int'(pass), exp_pass);
    if (exp_pass == 0) chk(req, "final fail_cycle", int'(fail_cycle), exp_fc);
    for (int i = 0; i < NCH; i++) fmode[i] = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset done", int'(done), 0);
    chk("R1", "reset tc", int'(scan_tc), 1);
    run_one("R4", 1, 0, 0);
    fmode[0] = 2;
    run_one("R6", 0, 5, 0);
    run_one("R7", 1, 0, 0);
    fmode[2] = 3; fat[2] = 7;
    run_one("R4", 1, 0, 0);
    fmode[1] = 3; fat[1] = 15;
    run_one("R6", 0, 15, 0);
    fmode[1] = 1;
    run_one("R2", 0, 12, 1);
    fmode[0] = 3; fat[0] = 8;
    run_one("R4", 0, 8, 0);
    repeat (3) @(negedge clk);
    chk("R5", "held done", int'(done), 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule